// File: doc/BRIEF.md
# Release-Time Word-Update Combiner

This block sits beside a private cache on one node of a shared-memory machine. The machine runs a protocol where several nodes may write the same line at once, and changes are published only at synchronisation points. A write to a resident line only marks the touched word as dirty, and no traffic is generated. A write or read to an absent line raises a fetch request and waits for the fill, then completes as an ordinary hit.

When the processor asks for a release, the engine sweeps the cache one destination node at a time. It emits one update per dirty line: a header word carrying the line index and a bitmap of dirty words, followed by the new values of only those words, which are fetched from the data array through a read port. Updates bound for the same home node are packed into one packet until the next whole update would overflow the payload limit. After the update phase, a sweep ages every resident line and drops any line left untouched across two releases, sending a one-word invalidation to its home node. The release is granted once every packet sent has been acknowledged.

Top module: `wupd_combiner`

## Requirements
- R1: An access to a resident line while idle is accepted in the same cycle (`acc_ready` high). A write sets that word's dirty bit, and no packet word is emitted.
- R2: An access to a non-resident line raises `miss_valid` with `miss_line` from the next cycle on, with `acc_ready` held low. It completes in the cycle `fill_valid` is high, which installs the line with home `fill_home` and, for a write, sets the written word's dirty bit.
- R3: An update is a header word followed by the data words of its set bitmap bits in ascending word order. The header holds kind 2'b01 in bits [31:30], the line index in bits [10:8] and the dirty bitmap in bits [7:0]. The other header bits are zero.
- R4: Destinations are visited in ascending order, and lines in ascending index within a destination. Updates join the open packet while the total word count, headers included, stays at or below 32, and an update is never split. `pkt_first` marks a packet's first word, `pkt_last` its final word, and `pkt_dest` gives its home node.
- R5: `rel_done` pulses for one cycle only after one `ack_valid` pulse has been received for every packet sent in that release.
- R6: A line's dirty bits are cleared once its update is sent, so a following release with no new writes sends no update.
- R7: A resident line not referenced since before the previous release is invalidated at this release. The invalidation is a single-word packet with kind 2'b10 in bits [31:30], the line index in bits [10:8], a zero bitmap, sent to the line's home. The line then misses on its next access.
- R8: A line referenced between two releases survives the second one and still hits afterwards.
- R9: While `pkt_valid` is high and `pkt_ready` low, the packet word, flags and destination hold steady.
- R10: While a release is in progress, `acc_ready` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Processor access request |
| acc_write | input | 1 | Access is a write |
| acc_line | input | 3 | Line index of the access |
| acc_word | input | 3 | Word index of the access |
| acc_ready | output | 1 | Access completes this cycle |
| miss_valid | output | 1 | Fetch request for an absent line |
| miss_line | output | 3 | Line being fetched |
| fill_valid | input | 1 | Fetched line arrives |
| fill_home | input | 2 | Home node of the fetched line |
| rel_req | input | 1 | Release request pulse |
| rel_done | output | 1 | Release granted pulse |
| dat_line | output | 3 | Data-array read line |
| dat_word | output | 3 | Data-array read word |
| dat_rdata | input | 32 | Data-array read value, same cycle |
| pkt_valid | output | 1 | Packet word valid |
| pkt_ready | input | 1 | Network accepts the word |
| pkt_word | output | 32 | Packet word |
| pkt_first | output | 1 | First word of a packet |
| pkt_last | output | 1 | Final word of a packet |
| pkt_dest | output | 2 | Destination node of the packet |
| ack_valid | input | 1 | One packet acknowledged |

## Verification
The checks take for granted that the environment behaves as follows:
- `acc_valid` and the access fields stay steady until `acc_ready`.
- A fill arrives only while a miss is raised.
- No acknowledgement arrives for a packet that has not yet been sent.
- A release is requested only while no access is outstanding.

The directed tasks follow these rules. They hold each access until it is accepted and answer each miss with exactly one fill. They acknowledge only packets already seen complete at the port, and they issue releases only between accesses. Backpressure toggles `pkt_ready` every cycle, which keeps the hold rule exercised.

// File: rtl/wuc_pkg.sv
`timescale 1ns/1ps
package wuc_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_MISS, S_PSTART, S_EMIT, S_STALE, S_WAIT
  } wuc_state_e;

  localparam logic [1:0] KIND_UPD = 2'b01;
  localparam logic [1:0] KIND_INV = 2'b10;
endpackage

// File: rtl/wuc_rst_sync.sv
`timescale 1ns/1ps
module wuc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sh_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= 2'b00;
    else        sh_q <= {sh_q[0], 1'b1};
  end
  assign rst_n_sync = sh_q[1];
endmodule

// File: rtl/wuc_first_set.sv
`timescale 1ns/1ps
module wuc_first_set #(
  parameter int W = 8,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = |vec;
    idx   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/wuc_ack_ctr.sv
`timescale 1ns/1ps
module wuc_ack_ctr #(
  parameter int W = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  output logic zero
);
  logic [W-1:0] cnt_q, cnt_d;
  always_comb begin
    cnt_d = cnt_q;
    if (inc && !dec)                     cnt_d = cnt_q + 1'b1;
    else if (dec && !inc && cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
  assign zero = (cnt_q == '0);
endmodule

// File: rtl/wupd_combiner.sv
`timescale 1ns/1ps
module wupd_combiner
  import wuc_pkg::*;
#(
  parameter int NLINES    = 8,
  parameter int WORDS     = 8,
  parameter int NODES     = 4,
  parameter int WORD_W    = 32,
  parameter int PAY_WORDS = 32,
  parameter int AGE_LIM   = 2,
  parameter int OUT_W     = 6,
  localparam int LINE_W = $clog2(NLINES),
  localparam int WIX_W  = $clog2(WORDS),
  localparam int NODE_W = $clog2(NODES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [LINE_W-1:0] acc_line,
  input  logic [WIX_W-1:0]  acc_word,
  output logic              acc_ready,
  output logic              miss_valid,
  output logic [LINE_W-1:0] miss_line,
  input  logic              fill_valid,
  input  logic [NODE_W-1:0] fill_home,
  input  logic              rel_req,
  output logic              rel_done,
  output logic [LINE_W-1:0] dat_line,
  output logic [WIX_W-1:0]  dat_word,
  input  logic [WORD_W-1:0] dat_rdata,
  output logic              pkt_valid,
  input  logic              pkt_ready,
  output logic [WORD_W-1:0] pkt_word,
  output logic              pkt_first,
  output logic              pkt_last,
  output logic [NODE_W-1:0] pkt_dest,
  input  logic              ack_valid
);
  localparam int CNT_W = $clog2(PAY_WORDS + 1);
  localparam int AGE_W = $clog2(AGE_LIM + 1);

  function automatic int popc(input logic [WORDS-1:0] v);
    int n;
    n = 0;
    for (int i = 0; i < WORDS; i++) n += int'(v[i]);
    return n;
  endfunction

  function automatic logic [WORD_W-1:0] mk_hdr(input logic [1:0] kind,
                                               input logic [LINE_W-1:0] ln,
                                               input logic [WORDS-1:0] bm);
    logic [WORD_W-1:0] h;
    h = '0;
    h[WORD_W-1 -: 2]    = kind;
    h[WORDS +: LINE_W]  = ln;
    h[WORDS-1:0]        = bm;
    return h;
  endfunction

  logic rst_s;
  wuc_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_s));

  // state registers
  wuc_state_e        st_q, st_d;
  logic [NODE_W-1:0] dest_q, dest_d;
  logic [LINE_W-1:0] cur_q, cur_d;
  logic [WORDS-1:0]  rem_q, rem_d;
  logic              hdr_q, hdr_d;
  logic [CNT_W-1:0]  used_q, used_d;
  logic [LINE_W-1:0] stl_q, stl_d;
  logic [LINE_W-1:0] mline_q, mline_d;

  logic [NLINES-1:0] vld_q, vld_d, refd_q, refd_d;
  logic [NODE_W-1:0] home_q  [NLINES];
  logic [NODE_W-1:0] home_d  [NLINES];
  logic [WORDS-1:0]  dirty_q [NLINES];
  logic [WORDS-1:0]  dirty_d [NLINES];
  logic [AGE_W-1:0]  age_q   [NLINES];
  logic [AGE_W-1:0]  age_d   [NLINES];

  // candidate search
  logic [NLINES-1:0] hit_any, hit_aft;
  logic              any_found, aft_found, wix_found;
  logic [LINE_W-1:0] any_idx, aft_idx;
  logic [WIX_W-1:0]  wix;

  for (genvar g = 0; g < NLINES; g++) begin : g_cand
    assign hit_any[g] = vld_q[g] && (|dirty_q[g]) && (home_q[g] == dest_q);
    assign hit_aft[g] = hit_any[g] && (LINE_W'(g) > cur_q);
  end

  wuc_first_set #(.W(NLINES)) u_any (.vec(hit_any), .found(any_found), .idx(any_idx));
  wuc_first_set #(.W(NLINES)) u_aft (.vec(hit_aft), .found(aft_found), .idx(aft_idx));
  wuc_first_set #(.W(WORDS))  u_wrd (.vec(rem_q),   .found(wix_found), .idx(wix));

  logic inc, out_zero;
  wuc_ack_ctr #(.W(OUT_W)) u_ack (
    .clk(clk), .rst_n(rst_s), .inc(inc), .dec(ack_valid), .zero(out_zero)
  );

  int  size_cur;
  logic cont, upd_end, stale;

  assign dat_line   = cur_q;
  assign dat_word   = wix;
  assign miss_valid = (st_q == S_MISS);
  assign miss_line  = mline_q;

  always_comb begin
    size_cur = 1 + popc(dirty_q[cur_q]);
    cont     = aft_found &&
               (int'(used_q) + size_cur + 1 + popc(dirty_q[aft_idx]) <= PAY_WORDS);
    upd_end  = !hdr_q && wix_found && $onehot(rem_q);
    stale    = vld_q[stl_q] && !refd_q[stl_q] &&
               (age_q[stl_q] == AGE_W'(AGE_LIM - 1));
  end

  always_comb begin
    st_d = st_q; dest_d = dest_q; cur_d = cur_q; rem_d = rem_q; hdr_d = hdr_q;
    used_d = used_q; stl_d = stl_q; mline_d = mline_q;
    vld_d = vld_q; refd_d = refd_q; home_d = home_q; dirty_d = dirty_q; age_d = age_q;
    acc_ready = 1'b0; rel_done = 1'b0; inc = 1'b0;
    pkt_valid = 1'b0; pkt_word = '0; pkt_first = 1'b0; pkt_last = 1'b0; pkt_dest = dest_q;
    unique case (st_q)
      S_IDLE: begin
        if (rel_req) begin
          st_d = S_PSTART; dest_d = '0;
        end else if (acc_valid) begin
          if (vld_q[acc_line]) begin
            acc_ready = 1'b1;
            refd_d[acc_line] = 1'b1;
            if (acc_write) dirty_d[acc_line][acc_word] = 1'b1;
          end else begin
            st_d = S_MISS; mline_d = acc_line;
          end
        end
      end
      S_MISS: begin
        if (fill_valid) begin
          acc_ready = 1'b1;
          vld_d[mline_q]   = 1'b1;
          refd_d[mline_q]  = 1'b1;
          home_d[mline_q]  = fill_home;
          age_d[mline_q]   = '0;
          dirty_d[mline_q] = '0;
          if (acc_write) dirty_d[mline_q][acc_word] = 1'b1;
          st_d = S_IDLE;
        end
      end
      S_PSTART: begin
        if (any_found) begin
          cur_d = any_idx; hdr_d = 1'b1; used_d = '0; st_d = S_EMIT;
        end else if (dest_q == NODE_W'(NODES - 1)) begin
          st_d = S_STALE; stl_d = '0;
        end else begin
          dest_d = dest_q + 1'b1;
        end
      end
      S_EMIT: begin
        pkt_valid = 1'b1;
        pkt_first = hdr_q && (used_q == '0);
        pkt_word  = hdr_q ? mk_hdr(KIND_UPD, cur_q, dirty_q[cur_q]) : dat_rdata;
        pkt_last  = upd_end && !cont;
        if (pkt_ready) begin
          if (hdr_q) begin
            hdr_d = 1'b0; rem_d = dirty_q[cur_q];
          end else begin
            rem_d[wix] = 1'b0;
            if (upd_end) begin
              dirty_d[cur_q] = '0;
              if (cont) begin
                cur_d  = aft_idx;
                used_d = CNT_W'(int'(used_q) + size_cur);
                hdr_d  = 1'b1;
              end else begin
                inc  = 1'b1;
                st_d = S_PSTART;
              end
            end
          end
        end
      end
      S_STALE: begin
        if (stale) begin
          pkt_valid = 1'b1; pkt_first = 1'b1; pkt_last = 1'b1;
          pkt_dest  = home_q[stl_q];
          pkt_word  = mk_hdr(KIND_INV, stl_q, dirty_q[stl_q]);
        end
        if (!stale || pkt_ready) begin
          if (stale) begin
            vld_d[stl_q] = 1'b0; age_d[stl_q] = '0; inc = 1'b1;
          end else if (vld_q[stl_q]) begin
            age_d[stl_q] = refd_q[stl_q] ? '0 : age_q[stl_q] + 1'b1;
          end
          refd_d[stl_q] = 1'b0;
          if (stl_q == LINE_W'(NLINES - 1)) st_d = S_WAIT;
          else                               stl_d = stl_q + 1'b1;
        end
      end
      S_WAIT: begin
        if (out_zero) begin
          rel_done = 1'b1; st_d = S_IDLE;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      st_q <= S_IDLE; dest_q <= '0; cur_q <= '0; rem_q <= '0; hdr_q <= 1'b0;
      used_q <= '0; stl_q <= '0; mline_q <= '0; vld_q <= '0; refd_q <= '0;
      for (int i = 0; i < NLINES; i++) begin
        home_q[i] <= '0; dirty_q[i] <= '0; age_q[i] <= '0;
      end
    end else begin
      st_q <= st_d; dest_q <= dest_d; cur_q <= cur_d; rem_q <= rem_d; hdr_q <= hdr_d;
      used_q <= used_d; stl_q <= stl_d; mline_q <= mline_d; vld_q <= vld_d; refd_q <= refd_d;
      home_q <= home_d; dirty_q <= dirty_d; age_q <= age_d;
    end
  end
endmodule

// File: rtl/wupd_combiner_chk.sv
`timescale 1ns/1ps
module wupd_combiner_chk #(
  parameter int WORD_W    = 32,
  parameter int PAY_WORDS = 32,
  parameter int NODE_W    = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_ready,
  input logic              miss_valid,
  input logic              fill_valid,
  input logic              rel_done,
  input logic              pkt_valid,
  input logic              pkt_ready,
  input logic [WORD_W-1:0] pkt_word,
  input logic              pkt_first,
  input logic              pkt_last,
  input logic [NODE_W-1:0] pkt_dest,
  input logic              ack_valid
);
  logic [7:0] wcnt_q, outst_q;
  logic       fire;
  assign fire = pkt_valid && pkt_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt_q <= '0; outst_q <= '0;
    end else begin
      if (fire) wcnt_q <= pkt_last ? 8'd0 : (pkt_first ? 8'd1 : wcnt_q + 8'd1);
      outst_q <= outst_q + {7'd0, fire && pkt_last} - {7'd0, ack_valid};
    end
  end

  p_miss_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && !fill_valid) |-> !acc_ready);
  p_first_hdr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && pkt_first) |-> (pkt_word[WORD_W-1 -: 2] != 2'b00));
  p_pay_limit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !pkt_first) |-> (int'(wcnt_q) < PAY_WORDS));
  p_dest_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !pkt_last) |=> (pkt_valid && $stable(pkt_dest)));
  p_done_acked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rel_done |-> (outst_q == 8'd0));
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && !pkt_ready) |=> (pkt_valid && $stable(pkt_word) &&
      $stable(pkt_first) && $stable(pkt_last) && $stable(pkt_dest)));
  p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |-> !acc_ready);
endmodule

bind wupd_combiner wupd_combiner_chk #(
  .WORD_W(WORD_W), .PAY_WORDS(PAY_WORDS), .NODE_W(NODE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_ready(acc_ready), .miss_valid(miss_valid),
  .fill_valid(fill_valid), .rel_done(rel_done), .pkt_valid(pkt_valid),
  .pkt_ready(pkt_ready), .pkt_word(pkt_word), .pkt_first(pkt_first),
  .pkt_last(pkt_last), .pkt_dest(pkt_dest), .ack_valid(ack_valid)
);

// File: tb/sim_wupd_combiner.sv
`timescale 1ns/1ps
module sim_wupd_combiner;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic acc_valid = 0, acc_write = 0, fill_valid = 0, rel_req = 0, pkt_ready = 1, ack_valid = 0;
  logic [2:0] acc_line = 0, acc_word = 0;
  logic [1:0] fill_home = 0;
  logic acc_ready, miss_valid, rel_done, pkt_valid, pkt_first, pkt_last;
  logic [2:0] miss_line, dat_line, dat_word;
  logic [1:0] pkt_dest;
  logic [31:0] pkt_word, dat_rdata;

  assign dat_rdata = {8'hD0, 5'b0, dat_line, 5'b0, dat_word, 8'h5A};

  wupd_combiner u0 (.*);

  int checks = 0, fails = 0, done_cnt = 0, nlog = 0, npkt = 0, exp_n = 0;
  bit bp_en = 0, finished = 0;
  logic [31:0] log_w [64];
  logic [2:0]  log_f [64];
  logic [31:0] exp_w [64];
  logic [2:0]  exp_f [64];

  function automatic logic [31:0] dval(input int ln, input int wd);
    return {8'hD0, 5'b0, 3'(ln), 5'b0, 3'(wd), 8'h5A};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && pkt_valid && pkt_ready) begin
      if (nlog < 64) begin
        log_w[nlog] = pkt_word;
        log_f[nlog] = {pkt_first, pkt_last, 1'b0} | {2'b00, 1'b0};
        log_f[nlog][0] = pkt_dest[0];
        log_f[nlog] = {pkt_first, pkt_last, pkt_dest[0]};
      end
      nlog++;
      if (pkt_last) npkt++;
    end
    if (rst_n && rel_done) done_cnt++;
  end

  always @(posedge clk) begin
    #1;
    if (bp_en) pkt_ready = ~pkt_ready;
    else       pkt_ready = 1'b1;
  end

  task automatic add_upd(input int dest, input int ln, input logic [7:0] bm,
                         input bit first, input bit last);
    int cnt, k;
    cnt = 0;
    for (int b = 0; b < 8; b++) cnt += int'(bm[b]);
    exp_w[exp_n] = {2'b01, 19'b0, 3'(ln), bm};
    exp_f[exp_n] = {first, 1'b0, 1'(dest)};
    exp_n++;
    k = 0;
    for (int b = 0; b < 8; b++) begin
      if (bm[b]) begin
        k++;
        exp_w[exp_n] = dval(ln, b);
        exp_f[exp_n] = {1'b0, last && (k == cnt), 1'(dest)};
        exp_n++;
      end
    end
  endtask

  task automatic add_inv(input int dest, input int ln);
    exp_w[exp_n] = {2'b10, 19'b0, 3'(ln), 8'h00};
    exp_f[exp_n] = {1'b1, 1'b1, 1'(dest)};
    exp_n++;
  endtask

  task automatic do_acc(input int ln, input int wd, input bit wr,
                        input int home, output bit missed);
    missed = 0;
    @(posedge clk); #1;
    acc_valid = 1; acc_write = wr; acc_line = 3'(ln); acc_word = 3'(wd);
    @(negedge clk);
    while (!acc_ready) begin
      if (miss_valid && !fill_valid) begin
        missed = 1;
        check(miss_line == 3'(ln), "R2", "miss_line", 32'(miss_line), 32'(ln));
        fill_valid = 1; fill_home = 2'(home);
        #1;
      end else @(negedge clk);
    end
    @(posedge clk); #1;
    acc_valid = 0; fill_valid = 0;
  endtask

  task automatic do_release(input int exp_pkts, input bit hold, input string req);
    int d0;
    nlog = 0; npkt = 0; d0 = done_cnt;
    @(posedge clk); #1 rel_req = 1;
    @(posedge clk); #1 rel_req = 0;
    for (int c = 0; c < 400 && npkt < exp_pkts; c++) @(negedge clk);
    if (hold) begin
      for (int c = 0; c < 12; c++) @(negedge clk);
      check(done_cnt == d0, "R5", "grant before acks", 32'(done_cnt - d0), 0);
      acc_valid = 1; acc_write = 0; acc_line = 3'd5; acc_word = 3'd0;
      #1;
      check(acc_ready == 1'b0, "R10", "access taken during release", 32'(acc_ready), 0);
      acc_valid = 0;
    end
    for (int k = 0; k < npkt; k++) begin
      @(posedge clk); #1 ack_valid = 1;
      @(posedge clk); #1 ack_valid = 0;
    end
    for (int c = 0; c < 100 && done_cnt == d0; c++) @(negedge clk);
    repeat (3) @(negedge clk);
    check(done_cnt == d0 + 1, req, "release grant pulses", 32'(done_cnt - d0), 1);
    check(npkt == exp_pkts, req, "packet count", 32'(npkt), 32'(exp_pkts));
  endtask

  task automatic compare_log(input string req);
    check(nlog == exp_n, req, "word count", 32'(nlog), 32'(exp_n));
    for (int i = 0; i < exp_n && i < nlog; i++) begin
      check(log_w[i] == exp_w[i], req, $sformatf("word %0d", i), log_w[i], exp_w[i]);
      check(log_f[i] == exp_f[i], req, $sformatf("flags %0d", i), 32'(log_f[i]), 32'(exp_f[i]));
    end
  endtask

  task automatic t_reset();
    check(pkt_valid == 0, "R10", "reset pkt_valid", 32'(pkt_valid), 0);
    check(miss_valid == 0, "R2", "reset miss_valid", 32'(miss_valid), 0);
    check(rel_done == 0, "R5", "reset rel_done", 32'(rel_done), 0);
  endtask

  task automatic t_fill_lines();
    bit m;
    do_acc(0, 0, 1, 0, m);
    check(m == 1, "R2", "write miss on empty line", 32'(m), 1);
    do_acc(0, 1, 1, 0, m);
    check(m == 0, "R1", "write hit no miss", 32'(m), 0);
    for (int w = 2; w < 8; w++) do_acc(0, w, 1, 0, m);
    for (int ln = 1; ln < 4; ln++)
      for (int w = 0; w < 8; w++) do_acc(ln, w, 1, 0, m);
    do_acc(4, 5, 1, 1, m);
    do_acc(4, 1, 1, 1, m);
    do_acc(5, 2, 0, 2, m);
    check(m == 1, "R2", "read miss", 32'(m), 1);
    check(nlog == 0, "R1", "no packet from writes", 32'(nlog), 0);
  endtask

  task automatic t_release_a();
    exp_n = 0;
    add_upd(0, 0, 8'hFF, 1, 0);
    add_upd(0, 1, 8'hFF, 0, 0);
    add_upd(0, 2, 8'hFF, 0, 1);
    add_upd(0, 3, 8'hFF, 1, 1);
    add_upd(1, 4, 8'h22, 1, 1);
    bp_en = 1;
    do_release(3, 1, "R5");
    bp_en = 0;
    compare_log("R4");
    check(log_w[27] == 32'h4000_03FF, "R3", "header of line 3", log_w[27], 32'h4000_03FF);
  endtask

  task automatic t_release_b();
    bit m;
    exp_n = 0;
    do_release(0, 0, "R6");
    check(nlog == 0, "R6", "no update after clean", 32'(nlog), 0);
    do_acc(2, 0, 0, 0, m);
    check(m == 0, "R8", "line 2 still resident", 32'(m), 0);
  endtask

  task automatic t_release_c();
    bit m;
    exp_n = 0;
    add_inv(0, 0); add_inv(0, 1); add_inv(0, 3); add_inv(1, 4); add_inv(2, 5);
    do_release(5, 0, "R7");
    compare_log("R7");
    do_acc(2, 3, 1, 0, m);
    check(m == 0, "R8", "referenced line survives", 32'(m), 0);
    do_acc(0, 0, 0, 0, m);
    check(m == 1, "R7", "invalidated line misses", 32'(m), 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    t_reset();
    t_fill_lines();
    t_release_a();
    t_release_b();
    t_release_c();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule